// File: doc/BRIEF.md
# Byte-Stream Frame Synchronizer

This block takes a stream of bytes, one byte per cycle in which a valid strobe is high, and finds the boundaries of fixed-length frames in it. A marker byte value and a frame length are supplied on two configuration inputs. The first byte of every frame equals the marker. Both inputs are held constant while the block runs. A new frame length takes effect after a reset.

After reset the block hunts: it drops every byte until the marker appears, and that byte opens the first frame. Once aligned, the block expects the marker again exactly one frame length later. If the marker is missing at that position, the block pulses an error and goes back to hunting. If the marker shows up earlier inside a frame, the block pulses an error and restarts the frame at that byte straight away, without a blind hunt in between. Aligned bytes are passed on with a frame-start flag or an in-frame flag. Two saturating counters record errors and detected markers.

Top module: `frame_sync`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_start`, `out_in_frame` and `err_pulse` are 0, `out_byte` is 0, and both counters read 0.
- R2: In the hunt state, a byte that differs from `sync_byte` produces no output (`out_valid` 0), no error pulse and no counter change.
- R3: In the hunt state, a byte equal to `sync_byte` locks the block. One cycle after that byte is accepted, `out_valid`=1, `out_start`=1, `out_byte` equals the byte, and `sync_count` has risen by 1.
- R4: In a locked frame, a non-marker byte at positions 1 to `frame_len`-1 (the marker is position 0) comes out one cycle later with `out_valid`=1, `out_in_frame`=1 and `out_start`=0. Whenever `out_valid` is 1, exactly one of `out_start` and `out_in_frame` is 1.
- R5: A marker at position `frame_len` (one frame length after the previous marker) comes out with `out_start`=1 and `err_pulse`=0, starts the next frame, and raises `sync_count` by 1. This allows frames to follow back to back.
- R6: A non-marker byte at position `frame_len` gives `err_pulse`=1 for one cycle, raises `err_count` by 1, is not output, and returns the block to the hunt state.
- R7: A marker at a locked position from 1 to `frame_len`-1 gives `err_pulse`=1, raises both `err_count` and `sync_count` by 1, comes out with `out_start`=1, and becomes position 0 of a new frame.
- R8: A cycle with `in_valid`=0 changes no state. The next cycle shows `out_valid`=0 and `err_pulse`=0, and both counters are unchanged.
- R9: `err_count` and `sync_count` are 16 bits wide. They stop at 65535 and clear only on reset.
- R10: While `frame_len` is 0 or 1, `config_error` is 1 and the block stays in the hunt state, so no byte, not even a marker, produces output or changes a counter. For any other `frame_len`, `config_error` is 0.
- R11: When `out_valid` is 0, `out_byte`, `out_start` and `out_in_frame` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` for one cycle |
| in_byte | input | 8 | Incoming byte |
| sync_byte | input | 8 | Marker value that opens each frame |
| frame_len | input | 8 | Frame length in bytes, marker included |
| out_valid | output | 1 | Aligned byte present on `out_byte` |
| out_byte | output | 8 | Aligned byte |
| out_start | output | 1 | Output byte is a frame's marker |
| out_in_frame | output | 1 | Output byte is payload |
| err_pulse | output | 1 | One-cycle alignment error |
| err_count | output | 16 | Saturating count of alignment errors |
| sync_count | output | 16 | Saturating count of accepted markers |
| config_error | output | 1 | Frame length is 0 or 1 |

## Verification
The hardest situation to reach from the ports is counter saturation. It takes tens of thousands of counted events, and a normal frame produces only one event per frame. The stimulus reaches it with the longest frame length and an unbroken run of marker bytes. Every marker after the first is then an early marker, so each byte raises both counters together, and both reach the limit in about 65,536 cycles. Early and missing markers are also hard to hit by chance. The random phase therefore corrupts marker slots and plants markers inside payload at fixed rates, and a bench model predicts every output cycle.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_t;

  // One flag per way a qualified byte can be classified.
  typedef struct packed {
    logic hunt_lock;  // marker found while hunting
    logic on_time;    // marker at the expected boundary
    logic missing;    // boundary reached, marker absent
    logic early;      // marker inside a locked frame
    logic payload;    // ordinary byte inside a locked frame
  } sync_evt_t;

endpackage

// File: rtl/fsync_classify.sv
module fsync_classify
  import fsync_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              valid,
  input  logic [BYTE_W-1:0] din,
  input  logic [BYTE_W-1:0] marker,
  input  logic [LEN_W-1:0]  frame_len,
  input  sync_state_t       state,
  input  logic [LEN_W-1:0]  pos,
  output sync_evt_t         evt,
  output logic              cfg_ok
);

  // A frame needs a marker and at least one payload byte.
  function automatic logic f_len_ok(input logic [LEN_W-1:0] len);
    return len > LEN_W'(1);
  endfunction

  // The next marker is due once the position reaches the frame length.
  function automatic logic f_at_boundary(input logic [LEN_W-1:0] p,
                                         input logic [LEN_W-1:0] len);
    return p >= len;
  endfunction

  logic is_marker;

  assign cfg_ok    = f_len_ok(frame_len);
  assign is_marker = (din == marker);

  always_comb begin
    evt = '0;
    if (valid && cfg_ok) begin
      if (state == ST_HUNT) begin
        evt.hunt_lock = is_marker;
      end else if (f_at_boundary(pos, frame_len)) begin
        evt.on_time = is_marker;
        evt.missing = !is_marker;
      end else begin
        evt.early   = is_marker;
        evt.payload = !is_marker;
      end
    end
  end

endmodule

// File: rtl/fsync_pos.sv
module fsync_pos #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  output logic [LEN_W-1:0] pos
);

  localparam logic [LEN_W-1:0] POS_MAX = '1;

  function automatic logic [LEN_W-1:0] f_step(input logic [LEN_W-1:0] p);
    return (p == POS_MAX) ? p : p + LEN_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (restart) pos <= LEN_W'(1);
    else if (advance) pos <= f_step(pos);
  end

  // R7: every restart leaves the counter just past the marker.
  p_restart_one_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> pos == LEN_W'(1));

  p_pos_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!restart && !advance) |=> $stable(pos));

endmodule

// File: rtl/fsync_sat_ctr.sv
module fsync_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  function automatic logic [W-1:0] f_sat_inc(input logic [W-1:0] c);
    return (c == CNT_MAX) ? c : c + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= f_sat_inc(cnt);
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    cnt == CNT_MAX |=> cnt == CNT_MAX);

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + W'(1));

  p_count_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/frame_sync.sv
module frame_sync
  import fsync_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] sync_byte,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_start,
  output logic              out_in_frame,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  sync_count,
  output logic              config_error
);

  localparam int N_CTR    = 2;
  localparam int CTR_ERR  = 0;
  localparam int CTR_SYNC = 1;

  sync_state_t       state;
  sync_state_t       state_nxt;
  sync_evt_t         evt;
  logic              cfg_ok;
  logic [LEN_W-1:0]  pos;

  // Named internal events, used by the counters, the position and the checks.
  logic ev_restart;
  logic ev_error;
  logic ev_marker;
  logic ev_emit;

  fsync_classify #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_classify (
    .valid     (in_valid),
    .din       (in_byte),
    .marker    (sync_byte),
    .frame_len (frame_len),
    .state     (state),
    .pos       (pos),
    .evt       (evt),
    .cfg_ok    (cfg_ok)
  );

  assign ev_restart = evt.hunt_lock | evt.on_time | evt.early;
  assign ev_marker  = ev_restart;
  assign ev_error   = evt.missing | evt.early;
  assign ev_emit    = ev_restart | evt.payload;

  fsync_pos #(.LEN_W(LEN_W)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .restart (ev_restart),
    .advance (evt.payload),
    .pos     (pos)
  );

  logic [N_CTR-1:0] ctr_inc;
  logic [CNT_W-1:0] ctr_val [N_CTR];

  assign ctr_inc[CTR_ERR]  = ev_error;
  assign ctr_inc[CTR_SYNC] = ev_marker;

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    fsync_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .inc (ctr_inc[g]),
      .cnt (ctr_val[g])
    );
  end

  assign err_count  = ctr_val[CTR_ERR];
  assign sync_count = ctr_val[CTR_SYNC];

  always_comb begin
    state_nxt = state;
    if (!cfg_ok)            state_nxt = ST_HUNT;
    else if (evt.hunt_lock) state_nxt = ST_LOCK;
    else if (evt.missing)   state_nxt = ST_HUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HUNT;
    else     state <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_byte     <= '0;
      out_start    <= 1'b0;
      out_in_frame <= 1'b0;
      err_pulse    <= 1'b0;
    end else begin
      out_valid    <= ev_emit;
      out_byte     <= ev_emit ? in_byte : '0;
      out_start    <= ev_restart;
      out_in_frame <= evt.payload;
      err_pulse    <= ev_error;
    end
  end

  assign config_error = !cfg_ok;

  // R4: a valid byte carries exactly one of the two position flags.
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_start ^ out_in_frame));

  // R11: nothing leaks out while no byte is presented.
  p_quiet_out_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_byte == '0 && !out_start && !out_in_frame));

  // R8: an idle input cycle yields an idle output cycle.
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !err_pulse));

  // R6: a missing marker sends the block back to hunting.
  p_miss_hunt_r6: assert property (@(posedge clk) disable iff (rst)
    evt.missing |=> (state == ST_HUNT && err_pulse && !out_valid));

  // R7: an early marker realigns immediately and reports an error.
  p_early_realign_r7: assert property (@(posedge clk) disable iff (rst)
    evt.early |=> (state == ST_LOCK && err_pulse && out_start));

  // R10: an unusable frame length keeps the output silent.
  p_cfg_silent_r10: assert property (@(posedge clk) disable iff (rst)
    config_error |=> (!out_valid && state == ST_HUNT));

endmodule

// File: tb/tb_frame_sync.sv
module tb_frame_sync;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic [7:0]  sync_byte;
  logic [7:0]  frame_len;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_start;
  logic        out_in_frame;
  logic        err_pulse;
  logic [15:0] err_count;
  logic [15:0] sync_count;
  logic        config_error;

  always #2 clk = ~clk;  // 250 MHz

  frame_sync dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .sync_byte(sync_byte), .frame_len(frame_len),
    .out_valid(out_valid), .out_byte(out_byte), .out_start(out_start),
    .out_in_frame(out_in_frame), .err_pulse(err_pulse),
    .err_count(err_count), .sync_count(sync_count),
    .config_error(config_error)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model state, written from the requirements.
  bit   m_locked;
  int   m_pos;
  int   m_err, m_sync;
  bit   e_valid, e_start, e_frame, e_err;
  logic [7:0] e_byte;

  function automatic int sat16(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_locked = 0; m_pos = 0; m_err = 0; m_sync = 0;
    e_valid = 0; e_start = 0; e_frame = 0; e_err = 0; e_byte = 8'h00;
  endtask

  task automatic model_step(input bit v, input logic [7:0] b);
    bit mk;
    e_valid = 0; e_start = 0; e_frame = 0; e_err = 0; e_byte = 8'h00;
    mk = (b == sync_byte);
    if (!v) return;
    if (frame_len < 2) begin
      m_locked = 0;
      return;
    end
    if (!m_locked) begin
      if (mk) begin
        m_locked = 1; m_pos = 1; m_sync = sat16(m_sync + 1);
        e_valid = 1; e_start = 1; e_byte = b;
      end
    end else if (m_pos >= frame_len) begin
      if (mk) begin
        m_pos = 1; m_sync = sat16(m_sync + 1);
        e_valid = 1; e_start = 1; e_byte = b;
      end else begin
        m_locked = 0; m_err = sat16(m_err + 1); e_err = 1;
      end
    end else if (mk) begin
      m_pos = 1; m_sync = sat16(m_sync + 1); m_err = sat16(m_err + 1);
      e_err = 1; e_valid = 1; e_start = 1; e_byte = b;
    end else begin
      m_pos++; e_valid = 1; e_frame = 1; e_byte = b;
    end
  endtask

  task automatic compare_all(input string tag);
    check(out_valid == e_valid, tag, "out_valid", out_valid, e_valid);
    check(out_byte == e_byte, tag, "out_byte", out_byte, e_byte);
    check(out_start == e_start, tag, "out_start", out_start, e_start);
    check(out_in_frame == e_frame, tag, "out_in_frame", out_in_frame, e_frame);
    check(err_pulse == e_err, tag, "err_pulse", err_pulse, e_err);
    check(err_count == 16'(m_err), tag, "err_count", err_count, m_err);
    check(sync_count == 16'(m_sync), tag, "sync_count", sync_count, m_sync);
    check(config_error == (frame_len < 2), tag, "config_error",
          config_error, frame_len < 2);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit v, input logic [7:0] b, input string tag);
    in_valid = v; in_byte = b;
    model_step(v, b);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset(input logic [7:0] len, input logic [7:0] mk);
    rst = 1; in_valid = 0; in_byte = 8'h00;
    frame_len = len; sync_byte = mk;
    repeat (3) @(negedge clk);
    model_reset();
    compare_all("R1");
    rst = 0;
    @(negedge clk);
    compare_all("R1");
  endtask

  function automatic logic [7:0] non_marker();
    logic [7:0] r;
    r = 8'($urandom);
    if (r == sync_byte) r = r + 8'd1;
    return r;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    rst = 1; in_valid = 0; in_byte = 0; frame_len = 4; sync_byte = 8'hA5;
    @(negedge clk);
    do_reset(8'd4, 8'hA5);
    check(out_valid == 0 && err_count == 0 && sync_count == 0, "R1",
          "reset state", out_valid, 0);

    // Hunting and first lock.
    step(1, 8'h11, "R2");
    check(out_valid == 0 && err_pulse == 0, "R2", "hunt drop", out_valid, 0);
    step(1, 8'hA5, "R3");
    check(out_start == 1 && sync_count == 1, "R3", "lock", sync_count, 1);
    step(1, 8'h01, "R4");
    check(out_in_frame == 1 && out_byte == 8'h01, "R4", "payload",
          out_byte, 1);
    step(0, 8'hA5, "R8");
    check(out_valid == 0 && sync_count == 1, "R8", "idle", sync_count, 1);
    step(1, 8'h02, "R4");
    step(1, 8'h03, "R4");
    step(1, 8'hA5, "R5");
    check(out_start == 1 && err_pulse == 0 && sync_count == 2, "R5",
          "on time", sync_count, 2);
    // Early marker at position 3 of 4.
    step(1, 8'h04, "R4");
    step(1, 8'h05, "R4");
    step(1, 8'hA5, "R7");
    check(err_pulse == 1 && out_start == 1 && err_count == 1 &&
          sync_count == 3, "R7", "early", err_count, 1);
    step(1, 8'h06, "R7");
    step(1, 8'h07, "R7");
    step(1, 8'h08, "R7");
    step(1, 8'hA5, "R7");
    check(out_start == 1 && err_pulse == 0 && sync_count == 4, "R7",
          "realigned frame", sync_count, 4);
    // Missing marker.
    step(1, 8'h09, "R4");
    step(1, 8'h0A, "R4");
    step(1, 8'h0B, "R4");
    step(1, 8'h33, "R6");
    check(err_pulse == 1 && out_valid == 0 && err_count == 2, "R6",
          "missing", err_count, 2);
    step(1, 8'h44, "R6");
    check(out_valid == 0, "R6", "back in hunt", out_valid, 0);
    step(1, 8'hA5, "R3");
    check(out_start == 1 && sync_count == 5, "R3", "relock", sync_count, 5);

    // New frame length after reset: back-to-back short frames.
    do_reset(8'd2, 8'h7E);
    step(1, 8'h7E, "R3");
    for (int i = 0; i < 6; i++) begin
      step(1, (i % 2 == 0) ? 8'h10 : 8'h7E, "R5");
    end
    check(sync_count == 4 && err_count == 0, "R5", "back-to-back",
          sync_count, 4);

    // Invalid lengths.
    do_reset(8'd1, 8'h7E);
    check(config_error == 1, "R10", "len 1 flagged", config_error, 1);
    step(1, 8'h7E, "R10");
    step(1, 8'h7E, "R10");
    check(out_valid == 0 && sync_count == 0, "R10", "len 1 silent",
          sync_count, 0);
    do_reset(8'd0, 8'h7E);
    step(1, 8'h7E, "R10");
    check(out_valid == 0 && config_error == 1, "R10", "len 0 silent",
          out_valid, 0);

    // Random frames with corruptions.
    do_reset(8'd6, 8'hC3);
    for (int k = 0; k < 4; k++) begin
      do_reset(8'(2 + $urandom_range(10)), 8'($urandom));
      for (int n = 0; n < 700; n++) begin
        int r;
        r = $urandom_range(99);
        if (r < 8)       step(0, 8'($urandom), "R8");
        else if (r < 14) step(1, sync_byte, "R7");
        else if (m_locked && m_pos >= frame_len)
          step(1, (r < 90) ? sync_byte : non_marker(), "R5");
        else             step(1, (r < 20) ? sync_byte : non_marker(), "R4");
      end
    end

    // Saturation: every marker after the first is early.
    do_reset(8'd255, 8'h5A);
    in_valid = 1; in_byte = 8'h5A;
    for (int n = 0; n < 65540; n++) model_step(1, 8'h5A);
    repeat (65540) @(negedge clk);
    in_valid = 0;
    check(err_count == 16'hFFFF, "R9", "err_count saturated", err_count, 65535);
    check(sync_count == 16'hFFFF, "R9", "sync_count saturated", sync_count,
          65535);
    model_step(0, 8'h00);
    @(negedge clk);
    compare_all("R9");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule